// File: doc/BRIEF.md
# Reloadable Baud Rate Divider

This block generates the bit-rate strobe for a serial transmitter by dividing the system clock by a programmable amount. Software programs a 15-bit divisor through a 16-bit register window. The window is split into two byte lanes. Byte enables select the lanes, so software can write one lane or both lanes in a single access.

A down-counter runs from the programmed divisor to zero. It then reloads and raises a one-clock strobe, so the strobe repeats every divisor+1 clocks. Any accepted write restarts the counter at once from the new divisor. A read of the window returns the live counter value, not the divisor, so software can see how far the current bit period has advanced.

Top module: `baud_reload_div`

## Requirements
- R1: After reset, the stored divisor, the counter, `rd_data` and `baud_tick` are all zero.
- R2: `rd_data` always shows the live counter value in bits 14..0, and bit 15 reads as 0.
- R3: A write is accepted when `wr_en` is high and at least one bit of `wr_be` is set. On the next clock the counter holds the newly merged divisor and `baud_tick` is low.
- R4: `wr_be[0]` writes divisor bits 7..0 from `wr_data[7:0]`. `wr_be[1]` writes divisor bits 14..8 from `wr_data[14:8]`. A lane that is not enabled keeps its old bits, and `wr_data[15]` is ignored.
- R5: With no accepted write and a nonzero counter, the counter drops by one on each clock and `baud_tick` stays low.
- R6: With no accepted write and a counter at zero, the next clock loads the stored divisor into the counter and raises `baud_tick` for that one cycle. The strobe period is therefore divisor+1 clocks.
- R7: With a divisor of zero, `baud_tick` is high on every clock.
- R8: When an accepted write falls in the same cycle in which the counter sits at zero, the counter takes the written value and no strobe is produced in that cycle.
- R9: A write with `wr_be` equal to 0, or any access with `wr_en` low, changes neither the divisor nor the counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register window |
| wr_be | input | 2 | Byte-lane enables (bit 0: low lane, bit 1: high lane) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Live counter value, zero-extended |
| baud_tick | output | 1 | One-clock bit-rate strobe |

## Verification
The bench aims at a write that lands in the same cycle as counter expiry. A design that gives the counter path priority here would emit a stray strobe, or restart from the old divisor. Single-lane writes check that the other lane keeps its bits. A wrong merge would zero that lane or copy stray data into it, and a write to the top data bit would show up as bit 15 on reads. A divisor of zero and a write with no lanes enabled are also exercised. A design that gets these wrong would stall the strobe, or restart the count on an empty access.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
    localparam int unsigned DEF_CNT_W = 15;
    localparam int unsigned DEF_BUS_W = 16;

    typedef enum logic [1:0] {
        ACT_LOAD   = 2'd0,
        ACT_RELOAD = 2'd1,
        ACT_DEC    = 2'd2
    } cnt_act_e;
endpackage

// File: rtl/baud_reload_reg.sv
module baud_reload_reg #(
    parameter int unsigned CNT_W  = baud_div_pkg::DEF_CNT_W,
    parameter int unsigned BUS_W  = baud_div_pkg::DEF_BUS_W,
    parameter int unsigned NBYTES = BUS_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              wr_hit,
    output logic [CNT_W-1:0]  merged,
    output logic [CNT_W-1:0]  reload_q
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
    } reg_st_t;

    reg_st_t st_d, st_q;

    assign wr_hit = wr_en && (|wr_be);

    // Per-lane merge: each enabled lane takes the bus data, others keep old bits
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        localparam int unsigned LO = 8 * b;
        localparam int unsigned HI = (8 * b + 7 < CNT_W) ? 8 * b + 7 : CNT_W - 1;
        if (LO < CNT_W) begin : g_used
            assign merged[HI:LO] = wr_be[b] ? wr_data[HI:LO] : st_q.reload[HI:LO];
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.reload = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_q = st_q.reload;
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
    parameter int unsigned CNT_W = baud_div_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             tick
);
    import baud_div_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } cnt_st_t;

    cnt_st_t  st_d, st_q;
    cnt_act_e act;

    // A write takes priority over expiry and suppresses the strobe
    always_comb begin
        if (load) begin
            act = ACT_LOAD;
        end else if (st_q.cnt == '0) begin
            act = ACT_RELOAD;
        end else begin
            act = ACT_DEC;
        end
    end

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_LOAD: begin
                st_d.cnt  = load_val;
                st_d.tick = 1'b0;
            end
            ACT_RELOAD: begin
                st_d.cnt  = reload_val;
                st_d.tick = 1'b1;
            end
            default: begin
                st_d.cnt  = st_q.cnt - 1'b1;
                st_d.tick = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign tick = st_q.tick;
endmodule

// File: rtl/baud_reload_div.sv
module baud_reload_div #(
    parameter int unsigned CNT_W = baud_div_pkg::DEF_CNT_W,
    parameter int unsigned BUS_W = baud_div_pkg::DEF_BUS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BUS_W/8-1:0]   wr_be,
    input  logic [BUS_W-1:0]     wr_data,
    output logic [BUS_W-1:0]     rd_data,
    output logic                 baud_tick
);
    localparam int unsigned NBYTES = BUS_W / 8;

    logic             wr_hit;
    logic [CNT_W-1:0] merged;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_val;

    baud_reload_reg #(
        .CNT_W (CNT_W),
        .BUS_W (BUS_W),
        .NBYTES(NBYTES)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .wr_hit  (wr_hit),
        .merged  (merged),
        .reload_q(reload_val)
    );

    baud_down_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_hit),
        .load_val  (merged),
        .reload_val(reload_val),
        .cnt       (cnt_val),
        .tick      (baud_tick)
    );

    // Unused upper window bits read as zero
    assign rd_data = BUS_W'(cnt_val);
endmodule

// File: rtl/baud_reload_div_chk.sv
module baud_reload_div_chk #(
    parameter int unsigned CNT_W  = 15,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned NBYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [NBYTES-1:0] wr_be,
    input logic [BUS_W-1:0]  rd_data,
    input logic              baud_tick,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  reload_val
);
    logic acc;
    assign acc = wr_en && (wr_be != '0);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BUS_W-1:CNT_W] == '0);

    assert_write_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (!baud_tick && rd_data[CNT_W-1:0] == reload_val));

    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && cnt_val != '0) |=> (!baud_tick && cnt_val == $past(cnt_val) - 1'b1));

    assert_expiry_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && cnt_val == '0) |=> (baud_tick && cnt_val == $past(reload_val)));

    assert_no_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(reload_val));
endmodule

bind baud_reload_div baud_reload_div_chk #(
    .CNT_W (CNT_W),
    .BUS_W (BUS_W),
    .NBYTES(NBYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .rd_data   (rd_data),
    .baud_tick (baud_tick),
    .cnt_val   (cnt_val),
    .reload_val(reload_val)
);

// File: tb/tb_baud_reload_div.sv
module tb_baud_reload_div;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        baud_tick;

    baud_reload_div dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .baud_tick(baud_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic        tick;
        logic [15:0] rd;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [14:0] m_rel = '0;
    logic [14:0] m_cnt = '0;
    logic        m_tick = 1'b0;

    // Driver: one bus cycle, then push the expected result of that edge
    task automatic step(input logic we, input logic [1:0] be,
                        input logic [15:0] d, input string tag);
        logic [14:0] nv;
        exp_t        e;
        wr_en   = we;
        wr_be   = be;
        wr_data = d;
        @(posedge clk);
        if (we && be != 2'b00) begin
            nv[7:0]  = be[0] ? d[7:0]  : m_rel[7:0];
            nv[14:8] = be[1] ? d[14:8] : m_rel[14:8];
            m_rel  = nv;
            m_cnt  = nv;
            m_tick = 1'b0;
        end else if (m_cnt == 15'd0) begin
            m_cnt  = m_rel;
            m_tick = 1'b1;
        end else begin
            m_cnt  = m_cnt - 15'd1;
            m_tick = 1'b0;
        end
        e.tick = m_tick;
        e.rd   = {1'b0, m_cnt};
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00, 16'h0000, tag);
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (baud_tick !== e.tick || rd_data !== e.rd) begin
                n_fail++;
                $display("FAIL %s: tick=%0b rd=%h expected tick=%0b rd=%h",
                         e.tag, baud_tick, rd_data, e.tick, e.rd);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        n_chk++;
        if (rd_data !== 16'h0000 || baud_tick !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rd=%h tick=%0b expected rd=0000 tick=0", rd_data, baud_tick);
        end
        @(negedge clk);
        rst_n = 1'b1;

        idle(3, "R1_R7 zero divisor after reset");
        step(1'b1, 2'b11, 16'h0005, "R3 word write");
        idle(13, "R5_R6 period six");
        step(1'b1, 2'b01, 16'hAB03, "R4 low lane only");
        idle(8, "R6 period four");
        step(1'b1, 2'b10, 16'h8102, "R4 high lane, bit 15 ignored");
        idle(3, "R2 live count readback");
        step(1'b1, 2'b11, 16'hFFFF, "R2_R4 full word write");
        idle(3, "R2 bit 15 zero");
        step(1'b1, 2'b11, 16'h0002, "R3 restart");
        while (m_cnt != 15'd0) step(1'b0, 2'b00, 16'h0000, "R5 run to zero");
        step(1'b1, 2'b11, 16'h0004, "R8 write at expiry");
        idle(6, "R8 period after collision");
        step(1'b1, 2'b00, 16'h0001, "R9 no lanes enabled");
        step(1'b0, 2'b11, 16'h0001, "R9 write strobe low");
        idle(5, "R9 counting undisturbed");
        step(1'b1, 2'b11, 16'h0000, "R7 write zero");
        idle(4, "R7 tick every cycle");

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule